// File: doc/BRIEF.md
# Host-Coprocessor Byte Mailbox

This block passes single bytes both ways between an 8-bit host bus and the register window of an embedded 32-bit coprocessor. Each direction has its own data byte and its own "pending" flag. The coprocessor can also raise an acknowledge flag. All three flags change only as side effects of ordinary register reads and writes. Reading a byte clears its pending flag, and reading the acknowledge location clears the acknowledge.

One status byte summarises the flags. Both sides can read it. The host also writes into this same status location to hold the coprocessor in reset or to let it run. When the host releases the coprocessor from reset, the block sends it a one-cycle restart pulse. Both buses use single-cycle access strobes in one clock domain. Read data is combinational on the address in the cycle of the strobe. Every flag, data byte and control change lands at the next clock edge.

Top module: `hostcop_mailbox`

## Requirements
- R1: After synchronous reset, `cop_reset` is 1, `cop_restart` is 0, all flags and data bytes are 0, and the status byte reads 0x00.
- R2: The host register is chosen by `h_addr & 0xFF06`. The value 0x3800 selects the inbound data byte, 0x3802 the outbound data/acknowledge location, and 0x3804 the status/control location. Aliases such as 0x38F9 therefore reach 0x3800.
- R3: A coprocessor write at offset 0x00 stores `c_wdata` and sets the to-host flag. A host read at 0x3800 returns that byte and clears the flag.
- R4: A host write at 0x3802 stores `h_wdata` and sets the to-coprocessor flag. A coprocessor read at offset 0x10 returns that byte and clears the flag.
- R5: A coprocessor write at offset 0x10 sets the acknowledge flag, whatever the data. A host read at 0x3802 clears it and returns `h_open_bus`.
- R6: The status byte has bit0 = to-host pending, bit2 = acknowledge, bit3 = to-coprocessor pending, and bit7 = coprocessor running (not in reset). All other bits are 0. A host read at 0x3804 returns it.
- R7: A host write at 0x3804 sets `cop_reset` to (value != 0) at the next edge. If the coprocessor was in reset and the value is 0, `cop_restart` is 1 for exactly that one following cycle. Otherwise it stays 0.
- R8: Host reads of undecoded offsets return `h_open_bus`. Coprocessor reads at offsets other than 0x10 and 0x20 return 0. Coprocessor writes at offsets other than 0x00 and 0x10 (including 0x20, 0x24, 0x28 and 0x2A) change no flag and no data.
- R9: When a flag is set and cleared in the same cycle, the set wins.
- R10: A coprocessor read at offset 0x20 returns the same status byte the host sees, and it clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_addr | input | 16 | Host address |
| h_wdata | input | 8 | Host write data |
| h_open_bus | input | 8 | Value returned for undecoded host reads |
| h_rdata | output | 8 | Host read data (combinational) |
| c_rd | input | 1 | Coprocessor read strobe, one cycle |
| c_wr | input | 1 | Coprocessor write strobe, one cycle |
| c_addr | input | 6 | Coprocessor register offset |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data (combinational) |
| cop_reset | output | 1 | Holds the coprocessor in reset when 1 |
| cop_restart | output | 1 | One-cycle pulse on release from reset |

## Verification
Each direction is exercised with a distinct byte (0xA5, 0x5A, 0x3C). This shows that the two data paths are kept apart and that read data is not taken from the wrong register. Aliased and near-miss host addresses (0x38F9 against 0x3806) show whether the mask is applied exactly. Reset-control writes of zero, of a non-zero value and of zero again while already running separate a true release from a plain write. Same-cycle set and clear collisions on the to-host and to-coprocessor flags show whether the set really takes priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam logic [15:0] H_MASK     = 16'hFF06;
    localparam logic [15:0] H_OFF_DATA = 16'h3800;
    localparam logic [15:0] H_OFF_XCHG = 16'h3802;
    localparam logic [15:0] H_OFF_CTL  = 16'h3804;

    localparam logic [5:0] C_OFF_DATA = 6'h00;
    localparam logic [5:0] C_OFF_XCHG = 6'h10;
    localparam logic [5:0] C_OFF_STAT = 6'h20;

    localparam int NFLAG = 3;

    typedef enum logic [1:0] {
        FL_TO_HOST = 2'd0,
        FL_ACK     = 2'd1,
        FL_TO_COP  = 2'd2
    } flag_e;

    typedef enum logic [1:0] {
        HS_NONE,
        HS_DATA,
        HS_XCHG,
        HS_CTL
    } hsel_e;

    typedef enum logic [1:0] {
        CS_ZERO,
        CS_DATA,
        CS_STAT
    } csel_e;

    typedef struct packed {
        logic rd_dat;
        logic rd_xchg;
        logic wr_xchg;
        logic wr_ctl;
    } hstb_t;

    typedef struct packed {
        logic wr_dat;
        logic wr_ack;
        logic rd_dat;
    } cstb_t;

    function automatic logic [7:0] pack_status(logic to_host, logic ack,
                                               logic to_cop, logic in_rst);
        return {~in_rst, 3'b000, to_cop, ack, 1'b0, to_host};
    endfunction

endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec
    import mbx_pkg::*;
#(
    parameter int HA_W = 16
) (
    input  logic            rd,
    input  logic            wr,
    input  logic [HA_W-1:0] addr,
    output hsel_e           sel,
    output hstb_t           stb
);
    localparam logic [HA_W-1:0] MASK   = HA_W'(H_MASK);
    localparam logic [HA_W-1:0] A_DATA = HA_W'(H_OFF_DATA);
    localparam logic [HA_W-1:0] A_XCHG = HA_W'(H_OFF_XCHG);
    localparam logic [HA_W-1:0] A_CTL  = HA_W'(H_OFF_CTL);

    logic [HA_W-1:0] masked;

    always_comb begin
        masked = addr & MASK;
        if (masked == A_DATA)      sel = HS_DATA;
        else if (masked == A_XCHG) sel = HS_XCHG;
        else if (masked == A_CTL)  sel = HS_CTL;
        else                       sel = HS_NONE;
        stb.rd_dat  = rd && (sel == HS_DATA);
        stb.rd_xchg = rd && (sel == HS_XCHG);
        stb.wr_xchg = wr && (sel == HS_XCHG);
        stb.wr_ctl  = wr && (sel == HS_CTL);
    end
endmodule

// File: rtl/mbx_cop_dec.sv
module mbx_cop_dec
    import mbx_pkg::*;
#(
    parameter int CA_W = 6
) (
    input  logic            rd,
    input  logic            wr,
    input  logic [CA_W-1:0] addr,
    output csel_e           sel,
    output cstb_t           stb
);
    localparam logic [CA_W-1:0] O_DATA = CA_W'(C_OFF_DATA);
    localparam logic [CA_W-1:0] O_XCHG = CA_W'(C_OFF_XCHG);
    localparam logic [CA_W-1:0] O_STAT = CA_W'(C_OFF_STAT);

    always_comb begin
        if (addr == O_XCHG)      sel = CS_DATA;
        else if (addr == O_STAT) sel = CS_STAT;
        else                     sel = CS_ZERO;
        stb.wr_dat = wr && (addr == O_DATA);
        stb.wr_ack = wr && (addr == O_XCHG);
        stb.rd_dat = rd && (addr == O_XCHG);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R9: a set in the same cycle as a clear still leaves the flag high
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    // R3/R4/R5: a lone clear drops the flag
    p_clear_alone_r3: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);
endmodule

// File: rtl/hostcop_mailbox.sv
module hostcop_mailbox
    import mbx_pkg::*;
#(
    parameter int HA_W = 16,
    parameter int CA_W = 6,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            h_rd,
    input  logic            h_wr,
    input  logic [HA_W-1:0] h_addr,
    input  logic [DW-1:0]   h_wdata,
    input  logic [DW-1:0]   h_open_bus,
    output logic [DW-1:0]   h_rdata,
    input  logic            c_rd,
    input  logic            c_wr,
    input  logic [CA_W-1:0] c_addr,
    input  logic [DW-1:0]   c_wdata,
    output logic [DW-1:0]   c_rdata,
    output logic            cop_reset,
    output logic            cop_restart
);
    hsel_e hsel;
    hstb_t hstb;
    csel_e csel;
    cstb_t cstb;

    logic [NFLAG-1:0] f_set, f_clr, f_q;
    logic [DW-1:0]    to_host_q, to_cop_q, status;

    mbx_host_dec #(.HA_W(HA_W)) u_hdec (
        .rd(h_rd), .wr(h_wr), .addr(h_addr), .sel(hsel), .stb(hstb)
    );

    mbx_cop_dec #(.CA_W(CA_W)) u_cdec (
        .rd(c_rd), .wr(c_wr), .addr(c_addr), .sel(csel), .stb(cstb)
    );

    always_comb begin
        f_set = '0;
        f_clr = '0;
        f_set[FL_TO_HOST] = cstb.wr_dat;
        f_clr[FL_TO_HOST] = hstb.rd_dat;
        f_set[FL_ACK]     = cstb.wr_ack;
        f_clr[FL_ACK]     = hstb.rd_xchg;
        f_set[FL_TO_COP]  = hstb.wr_xchg;
        f_clr[FL_TO_COP]  = cstb.rd_dat;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        mbx_flag u_flag (
            .clk(clk), .rst(rst), .set(f_set[i]), .clr(f_clr[i]), .q(f_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            to_host_q   <= '0;
            to_cop_q    <= '0;
            cop_reset   <= 1'b1;
            cop_restart <= 1'b0;
        end else begin
            cop_restart <= 1'b0;
            if (cstb.wr_dat)  to_host_q <= c_wdata;
            if (hstb.wr_xchg) to_cop_q  <= h_wdata;
            if (hstb.wr_ctl) begin
                cop_reset   <= |h_wdata;
                cop_restart <= cop_reset && (h_wdata == '0);
            end
        end
    end

    assign status = DW'(pack_status(f_q[FL_TO_HOST], f_q[FL_ACK],
                                    f_q[FL_TO_COP], cop_reset));

    always_comb begin
        unique case (hsel)
            HS_DATA: h_rdata = to_host_q;
            HS_CTL:  h_rdata = status;
            default: h_rdata = h_open_bus;
        endcase
        unique case (csel)
            CS_DATA: c_rdata = to_cop_q;
            CS_STAT: c_rdata = status;
            default: c_rdata = '0;
        endcase
    end

    // R7: the restart pulse only follows a release out of reset
    p_restart_on_release_r7: assert property (@(posedge clk) disable iff (rst)
        cop_restart |-> ($past(cop_reset) && !cop_reset));
    // R7: the restart pulse lasts a single cycle
    p_restart_single_r7: assert property (@(posedge clk) disable iff (rst)
        cop_restart |=> !cop_restart);
    // R7: writing zero to control always leaves the coprocessor running
    p_zero_runs_r7: assert property (@(posedge clk) disable iff (rst)
        (hstb.wr_ctl && h_wdata == '0) |=> !cop_reset);
    // R8: coprocessor writes off the decoded offsets leave the flags alone
    p_cop_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (c_wr && !cstb.wr_dat && !cstb.wr_ack && !c_rd && !h_rd && !h_wr)
        |=> $stable(f_q));
endmodule

// File: tb/hostcop_mailbox_bench.sv
module hostcop_mailbox_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       h_rd, h_wr, c_rd, c_wr;
    logic [15:0] h_addr;
    logic [7:0] h_wdata, h_open_bus, h_rdata, c_wdata, c_rdata;
    logic [5:0] c_addr;
    logic       cop_reset, cop_restart;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostcop_mailbox u_hostcop_mailbox (
        .clk(clk), .rst(rst),
        .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_open_bus(h_open_bus), .h_rdata(h_rdata),
        .c_rd(c_rd), .c_wr(c_wr), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .cop_reset(cop_reset), .cop_restart(cop_restart)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one strobe cycle on either or both sides; read data sampled before the edge
    task automatic cycle(input logic hr, input logic hw, input logic [15:0] ha,
                         input logic [7:0] hd, input logic cr, input logic cw,
                         input logic [5:0] ca, input logic [7:0] cd,
                         output logic [7:0] hq, output logic [7:0] cq);
        @(negedge clk);
        h_rd = hr; h_wr = hw; h_addr = ha; h_wdata = hd;
        c_rd = cr; c_wr = cw; c_addr = ca; c_wdata = cd;
        #1;
        hq = h_rdata; cq = c_rdata;
        @(posedge clk);
        #1;
        h_rd = 0; h_wr = 0; c_rd = 0; c_wr = 0;
    endtask

    task automatic host_rd(input logic [15:0] a, output logic [7:0] q);
        logic [7:0] dummy;
        cycle(1, 0, a, 8'h00, 0, 0, 6'h00, 8'h00, q, dummy);
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] x, y;
        cycle(0, 1, a, d, 0, 0, 6'h00, 8'h00, x, y);
    endtask

    task automatic cop_rd(input logic [5:0] a, output logic [7:0] q);
        logic [7:0] dummy;
        cycle(0, 0, 16'h0000, 8'h00, 1, 0, a, 8'h00, dummy, q);
    endtask

    task automatic cop_wr(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] x, y;
        cycle(0, 0, 16'h0000, 8'h00, 0, 1, a, d, x, y);
    endtask

    task automatic status_is(input string req, input logic [7:0] exp);
        logic [7:0] q;
        host_rd(16'h3804, q);
        chk(req, q, exp);
    endtask

    task automatic t_reset;
        chk("R1 cop_reset", {7'd0, cop_reset}, 8'h01);
        chk("R1 cop_restart", {7'd0, cop_restart}, 8'h00);
        status_is("R1 status after reset", 8'h00);
    endtask

    task automatic t_release;
        host_wr(16'h3804, 8'h00);
        chk("R7 released", {7'd0, cop_reset}, 8'h00);
        chk("R7 restart pulse", {7'd0, cop_restart}, 8'h01);
        @(posedge clk); #1;
        chk("R7 restart one cycle", {7'd0, cop_restart}, 8'h00);
        status_is("R6 running bit7", 8'h80);
        host_wr(16'h3804, 8'h05);
        chk("R7 nonzero holds reset", {7'd0, cop_reset}, 8'h01);
        chk("R7 no pulse entering reset", {7'd0, cop_restart}, 8'h00);
        status_is("R6 in reset bit7 low", 8'h00);
        host_wr(16'h3804, 8'h00);
        chk("R7 second release pulse", {7'd0, cop_restart}, 8'h01);
        host_wr(16'h3804, 8'h00);
        chk("R7 no pulse when already running", {7'd0, cop_restart}, 8'h00);
        chk("R7 still running", {7'd0, cop_reset}, 8'h00);
    endtask

    task automatic t_to_host;
        logic [7:0] q;
        cop_wr(6'h00, 8'hA5);
        status_is("R3 R6 to-host pending bit0", 8'h81);
        host_rd(16'h3800, q);
        chk("R3 host reads coprocessor byte", q, 8'hA5);
        status_is("R3 to-host cleared", 8'h80);
        cop_wr(6'h00, 8'h3C);
        host_rd(16'h38F9, q);
        chk("R2 aliased data read", q, 8'h3C);
        status_is("R2 alias read clears flag", 8'h80);
        host_rd(16'h3806, q);
        chk("R8 R2 near-miss address open bus", q, 8'hEE);
    endtask

    task automatic t_to_cop;
        logic [7:0] q;
        host_wr(16'h3802, 8'h5A);
        status_is("R4 R6 to-cop pending bit3", 8'h88);
        cop_rd(6'h20, q);
        chk("R10 coprocessor status", q, 8'h88);
        status_is("R10 status read clears nothing", 8'h88);
        cop_rd(6'h10, q);
        chk("R4 coprocessor reads host byte", q, 8'h5A);
        status_is("R4 to-cop cleared", 8'h80);
    endtask

    task automatic t_ack;
        logic [7:0] q;
        cop_wr(6'h10, 8'h00);
        status_is("R5 R6 ack bit2", 8'h84);
        host_rd(16'h3802, q);
        chk("R5 ack read returns open bus", q, 8'hEE);
        status_is("R5 ack cleared", 8'h80);
    endtask

    task automatic t_ignored;
        logic [7:0] q;
        cop_wr(6'h20, 8'hFF);
        cop_wr(6'h24, 8'hFF);
        cop_wr(6'h28, 8'hFF);
        cop_wr(6'h2A, 8'hFF);
        status_is("R8 ignored writes leave flags", 8'h80);
        host_rd(16'h3800, q);
        chk("R8 ignored writes leave to-host byte", q, 8'h3C);
        cop_rd(6'h10, q);
        chk("R8 ignored writes leave to-cop byte", q, 8'h5A);
        cop_rd(6'h04, q);
        chk("R8 unmapped coprocessor read zero", q, 8'h00);
        host_rd(16'h3000, q);
        chk("R8 undecoded host read open bus", q, 8'hEE);
    endtask

    task automatic t_collide;
        logic [7:0] hq, cq;
        cop_wr(6'h00, 8'h11);
        cycle(1, 0, 16'h3800, 8'h00, 0, 1, 6'h00, 8'h22, hq, cq);
        chk("R9 old byte during collision", hq, 8'h11);
        status_is("R9 to-host set beats clear", 8'h81);
        host_wr(16'h3802, 8'h33);
        cycle(0, 1, 16'h3802, 8'h44, 1, 0, 6'h10, 8'h00, hq, cq);
        chk("R9 coprocessor sees old byte", cq, 8'h33);
        status_is("R9 to-cop set beats clear", 8'h89);
        cycle(1, 0, 16'h3802, 8'h00, 0, 1, 6'h10, 8'h00, hq, cq);
        status_is("R9 ack set beats clear", 8'h8D);
        host_rd(16'h3800, hq);
        chk("R3 new byte after collision", hq, 8'h22);
    endtask

    initial begin
        rst = 1; h_rd = 0; h_wr = 0; c_rd = 0; c_wr = 0;
        h_addr = '0; h_wdata = '0; c_addr = '0; c_wdata = '0;
        h_open_bus = 8'hEE;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_release();
        t_to_host();
        t_to_cop();
        t_ack();
        t_ignored();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule